// File: doc/BRIEF.md
# Timer-Shared Port Direction Arbiter

This block decides, line by line, who drives each pin of an eight-line general-purpose port. The port's lines are shared with timer compare outputs, capture inputs and a pulse accumulator input. Each line has two software registers: a direction bit and a data latch. Each line also has two timer signals: a compare enable and a compare value. From these the block produces an output enable and an output value for every pin. An enabled compare takes the line without touching the direction register. When the compare is disabled again, the line returns to the direction register's control.

Line 3 is dual-purpose. A two-state mode machine sets its role. In compare mode, line 3 is the fifth compare output, and a shared register holding its compare setting can be written. In capture mode, line 3 is the fourth capture input and writes to that shared register are dropped. The level seen on each capture line, and on the accumulator line 7, is the driven value when the line drives and the pad level otherwise. Software writes to an output-configured line therefore appear at the timer.

Mode machine: states `L3_CMP` (reset state) and `L3_CAP`. Transition `to_cap` is a write of 1 to bit 0 of the mode register while in `L3_CMP`. Transition `to_cmp` is a write of 0 to that bit while in `L3_CAP`. Any other write to the mode register keeps the current state.

Top module: `tport_mux`

## Requirements
- R1: Register addresses are 0 data latch, 1 direction (bit set = output), 2 mode (bit 0 only, other bits read 0), 3 shared compare register. A read of address 0 returns, per bit, the data latch where the direction bit is 1 and `pin_in` where it is 0. Reads of addresses 1 to 3 return the stored value.
- R2: While the compare enable of a compare-capable line (lines 3 to 7) is active, and for line 3 only in compare mode, `pin_oe` of that line is 1 and `pin_out` equals its `cmp_val` bit, whatever the direction bit holds.
- R3: A compare override never changes the direction register. Once the compare is disabled, `pin_oe` follows the direction bit and `pin_out` follows the data latch.
- R4: Lines 0 to 2 have no compare. Their `pin_oe` equals the direction bit. `cap_o[0..2]` give each line's level: the driven value when the line drives, `pin_in` otherwise.
- R5: The mode machine resets to `L3_CMP`. In `L3_CAP`, `cmp_en[3]` has no effect on line 3's enable or value.
- R6: In `L3_CAP`, `cap_o[3]` is line 3's level. With its direction bit set, a write to the data latch that toggles bit 3 toggles `cap_o[3]` in the next cycle. In `L3_CMP`, `cap_o[3]` is 0.
- R7: A write to address 3 takes effect only in `L3_CMP`. In `L3_CAP` it is ignored and the stored value read back is unchanged.
- R8: `acc_o` is line 7's level: `pin_out[7]` when line 7 drives, `pin_in[7]` when it does not.
- R9: Reset is synchronous. During reset, the data latch loads `pin_in`. The direction register and the shared register reset to 0, and the mode machine resets to `L3_CMP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cmp_en | input | 8 | Per-line compare enables from the timer |
| cmp_val | input | 8 | Per-line compare output values |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |
| cap_o | output | 4 | Capture inputs (lines 0 to 3) |
| acc_o | output | 1 | Pulse accumulator input (line 7) |

## Verification
A wrong mode state is visible at the ports in the same cycle. It shows on `cap_o[3]`, on whether `cmp_en[3]` claims line 3, and on the mode register readback. A corrupted direction bit or data latch alters `pin_oe`, `pin_out` or the address-0 readback on the cycle after the offending write. A shared-register write that should have been dropped shows on the next read of address 3. Every output is compared against a reference model on every clock, so any divergence is reported within one cycle.

// File: rtl/tport_pkg.sv
package tport_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIR   = 2'd1;
    localparam logic [ADDR_W-1:0] A_MODE  = 2'd2;
    localparam logic [ADDR_W-1:0] A_SHARE = 2'd3;

    typedef enum logic {
        L3_CMP = 1'b0,
        L3_CAP = 1'b1
    } l3_state_e;
endpackage

// File: rtl/tport_l3_fsm.sv
module tport_l3_fsm
    import tport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic mode_sel,
    output logic cap_mode
);
    l3_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= L3_CMP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            unique case (state_q)
                L3_CMP: if (mode_sel)  state_d = L3_CAP;  // to_cap
                L3_CAP: if (!mode_sel) state_d = L3_CMP;  // to_cmp
                default: state_d = L3_CMP;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            L3_CMP:  cap_mode = 1'b0;
            L3_CAP:  cap_mode = 1'b1;
            default: cap_mode = 1'b0;
        endcase
    end
endmodule

// File: rtl/tport_regs.sv
module tport_regs
    import tport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      pin_in,
    input  logic              share_lock,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      share_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= pin_in;
            dir_q   <= '0;
            share_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_DATA:  data_q <= wr_data;
                A_DIR:   dir_q  <= wr_data;
                A_SHARE: if (!share_lock) share_q <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tport_line.sv
module tport_line (
    input  logic dir,
    input  logic data,
    input  logic cmp_take,
    input  logic cmp_bit,
    input  logic pad,
    output logic oe,
    output logic drv,
    output logic level,
    output logic rd_bit
);
    always_comb begin
        oe     = cmp_take | dir;
        drv    = cmp_take ? cmp_bit : data;
        level  = oe ? drv : pad;
        rd_bit = dir ? data : pad;
    end
endmodule

// File: rtl/tport_mux.sv
module tport_mux
    import tport_pkg::*;
#(
    parameter int          W           = 8,
    parameter int          SHARED_LINE = 3,
    parameter int          ACC_LINE    = 7,
    parameter logic [7:0]  CMP_MASK    = 8'hF8,
    localparam int         CAP_N       = SHARED_LINE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      cmp_en,
    input  logic [W-1:0]      cmp_val,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out,
    output logic [CAP_N-1:0]  cap_o,
    output logic              acc_o
);
    logic [W-1:0] data_q, dir_q, share_q;
    logic [W-1:0] cmp_take, level, rd_bits;
    logic         l3_cap;

    tport_l3_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (wr_en && wr_addr == A_MODE),
        .mode_sel (wr_data[0]),
        .cap_mode (l3_cap)
    );

    tport_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pin_in     (pin_in),
        .share_lock (l3_cap),
        .data_q     (data_q),
        .dir_q      (dir_q),
        .share_q    (share_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_line
        if (i == SHARED_LINE) begin : g_shared
            assign cmp_take[i] = CMP_MASK[i] && cmp_en[i] && !l3_cap;
        end else begin : g_plain
            assign cmp_take[i] = CMP_MASK[i] && cmp_en[i];
        end
        tport_line u_line (
            .dir      (dir_q[i]),
            .data     (data_q[i]),
            .cmp_take (cmp_take[i]),
            .cmp_bit  (cmp_val[i]),
            .pad      (pin_in[i]),
            .oe       (pin_oe[i]),
            .drv      (pin_out[i]),
            .level    (level[i]),
            .rd_bit   (rd_bits[i])
        );
    end

    for (genvar c = 0; c < SHARED_LINE; c++) begin : g_cap
        assign cap_o[c] = level[c];
    end
    assign cap_o[SHARED_LINE] = l3_cap & level[SHARED_LINE];
    assign acc_o = level[ACC_LINE];

    always_comb begin
        unique case (rd_addr)
            A_DATA:  rd_data = rd_bits;
            A_DIR:   rd_data = dir_q;
            A_MODE:  rd_data = {{(W-1){1'b0}}, l3_cap};
            A_SHARE: rd_data = share_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tport_mux_chk.sv
module tport_mux_chk
    import tport_pkg::*;
#(
    parameter int W = 8,
    parameter int SHARED_LINE = 3,
    parameter int ACC_LINE = 7,
    parameter int CAP_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      cmp_en,
    input logic [W-1:0]      cmp_val,
    input logic [W-1:0]      pin_in,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      pin_out,
    input logic [CAP_N-1:0]  cap_o,
    input logic              acc_o,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      share_q,
    input logic              l3_cap
);
    a_r2_cmp_claims_line: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en[ACC_LINE] |-> (pin_oe[ACC_LINE] && pin_out[ACC_LINE] == cmp_val[ACC_LINE]));

    a_r3_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_DIR) |=> $stable(dir_q));

    a_r4_cap_no_force: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_q[0] |-> !pin_oe[0]);

    a_r5_cap_mode_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (l3_cap && !dir_q[SHARED_LINE]) |-> !pin_oe[SHARED_LINE]);

    a_r6_cap_sees_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (l3_cap && pin_oe[SHARED_LINE]) |-> cap_o[SHARED_LINE] == pin_out[SHARED_LINE]);

    a_r7_share_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (l3_cap && wr_en && wr_addr == A_SHARE) |=> $stable(share_q));

    a_r8_acc_level: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o == (pin_oe[ACC_LINE] ? pin_out[ACC_LINE] : pin_in[ACC_LINE]));
endmodule

bind tport_mux tport_mux_chk #(
    .W(W), .SHARED_LINE(SHARED_LINE), .ACC_LINE(ACC_LINE), .CAP_N(CAP_N)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cmp_en(cmp_en), .cmp_val(cmp_val), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .cap_o(cap_o), .acc_o(acc_o),
    .dir_q(dir_q), .share_q(share_q), .l3_cap(l3_cap)
);

// File: tb/tport_mux_tb.sv
module tport_mux_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data, cmp_en, cmp_val, pin_in, pin_oe, pin_out;
    logic [3:0] cap_o;
    logic       acc_o;

    int checks = 0;
    int failures = 0;
    string phase = "R9";

    always #10 clk = ~clk;

    tport_mux dut_i (.*);

    // reference model state
    logic [7:0] m_data, m_dir, m_share;
    logic       m_cap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = pin_in; m_dir = 8'h00; m_share = 8'h00; m_cap = 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: m_data = wr_data;
                2'd1: m_dir = wr_data;
                2'd2: m_cap = wr_data[0];
                default: if (!m_cap) m_share = wr_data;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0] take, oe, drv, lvl, rd;
        take = cmp_en & 8'hF8;
        if (m_cap) take[3] = 1'b0;
        oe  = take | m_dir;
        drv = 8'h00;
        lvl = 8'h00;
        for (int i = 0; i < 8; i++) begin
            drv[i] = take[i] ? cmp_val[i] : m_data[i];
            lvl[i] = oe[i] ? drv[i] : pin_in[i];
        end
        case (rd_addr)
            2'd0: rd = (m_dir & m_data) | (~m_dir & pin_in);
            2'd1: rd = m_dir;
            2'd2: rd = {7'd0, m_cap};
            default: rd = m_share;
        endcase
        chk(phase, "pin_oe", pin_oe, oe);
        chk(phase, "pin_out", pin_out, drv);
        chk(phase, "rd_data", rd_data, rd);
        chk(phase, "cap_o", {4'd0, cap_o}, {4'd0, m_cap & lvl[3], lvl[2:0]});
        chk(phase, "acc_o", {7'd0, acc_o}, {7'd0, lvl[7]});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [1:0] ra);
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = ra;
        tick();
    endtask

    task automatic rd(input logic [1:0] ra);
        rd_addr = ra;
        tick();
    endtask

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        cmp_en = 0; cmp_val = 0; pin_in = 8'hA5;
        repeat (3) tick();
        rst_n = 1'b1;
        // R9: latch took pad levels during reset
        phase = "R9"; rd(2'd2); rd(2'd3); rd(2'd1);
        pin_in = 8'h00;
        wr(2'd1, 8'hFF, 2'd0); rd(2'd0);
        // R1: mixed direction readback
        phase = "R1";
        wr(2'd0, 8'h3C, 2'd0); wr(2'd1, 8'h0F, 2'd0);
        pin_in = 8'hC3; rd(2'd0); pin_in = 8'h5A; rd(2'd1); rd(2'd0);
        // R2: compare overrides direction
        phase = "R2";
        wr(2'd1, 8'h00, 2'd0);
        cmp_en = 8'hFF; cmp_val = 8'hA0; rd(2'd1); cmp_val = 8'h58; rd(2'd0);
        // R3: release restores direction control, register untouched
        phase = "R3";
        wr(2'd1, 8'h30, 2'd1); cmp_en = 8'h00; rd(2'd1); rd(2'd0);
        // R4: capture lines never forced
        phase = "R4";
        cmp_en = 8'h07; pin_in = 8'h05; wr(2'd1, 8'h02, 2'd0); pin_in = 8'h02; rd(2'd0);
        // R5: capture mode releases line 3
        phase = "R5";
        cmp_en = 8'h08; cmp_val = 8'h08; wr(2'd1, 8'h00, 2'd2);
        wr(2'd2, 8'h01, 2'd2); rd(2'd2); wr(2'd2, 8'hFE, 2'd2); wr(2'd2, 8'h01, 2'd2);
        // R6: software edges seen by capture
        phase = "R6";
        cmp_en = 8'h00; wr(2'd1, 8'h08, 2'd0);
        wr(2'd0, 8'h08, 2'd0); wr(2'd0, 8'h00, 2'd0); wr(2'd0, 8'h08, 2'd0);
        // R7: shared register locked in capture mode
        phase = "R7";
        wr(2'd3, 8'h77, 2'd3); rd(2'd3);
        wr(2'd2, 8'h00, 2'd3); wr(2'd3, 8'h99, 2'd3); rd(2'd3);
        wr(2'd2, 8'h01, 2'd3); wr(2'd3, 8'h11, 2'd3); rd(2'd3);
        // R8: accumulator follows line 7 in both directions
        phase = "R8";
        wr(2'd1, 8'h00, 2'd0); pin_in = 8'h80; rd(2'd0); pin_in = 8'h00; rd(2'd0);
        wr(2'd1, 8'h80, 2'd0); wr(2'd0, 8'h80, 2'd0); pin_in = 8'h00; rd(2'd0);
        cmp_en = 8'h80; cmp_val = 8'h00; rd(2'd0);
        // mixed traffic
        phase = "R1";
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pin_in = lfsr[7:0]; cmp_en = lfsr[15:8] & {lfsr[3:0], lfsr[7:4]};
            cmp_val = lfsr[11:4];
            wr_en = lfsr[0]; wr_addr = lfsr[5:4]; wr_data = lfsr[13:6]; rd_addr = lfsr[9:8];
            tick();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule